// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns digitized supply-health flags and a push-button style manual reset into one active-low system reset. Three synchronous "power good" flags (primary rail, secondary rail, adjustable rail) and an active-low manual reset pin feed a single fault condition. While any fault is present, the reset output is held low. Once every flag is good and the manual reset is released, the reset stays low for a selectable hold-off period and then rises. A fault that arrives during the hold-off clears the hold-off count, so the full period starts again.

The hold-off is measured in pulses of a free-running tick enable (nominally one per millisecond). There are six period lengths, chosen by a 3-bit select and given as tick-count parameters, so a simulation can scale them down. The manual reset pin is asynchronous to the clock. It passes a synchronizer and then a counting glitch filter, so short spikes are rejected and a held press is accepted. Two single-cycle strobes serve a companion watchdog: one marks each new assertion of reset, and the other marks the cycle in which reset is released. The block has no streaming data path. Every pin is a plain level or strobe with no handshake.

Top module: `supv_rst_seq`

## Requirements
- R1: When any of `pg_pri`, `pg_sec`, `pg_adj` is low at a clock edge, `rst_n` is low after that edge.
- R2: Once every flag is high and the filtered manual reset is released, `rst_n` rises on the clock edge that samples the N-th `tick_ms` pulse, where N is the selected period. It stays low after pulses 1 to N-1.
- R3: A fault during the hold-off restarts the count. After the fault clears, a full N further ticks are needed.
- R4: `rst_n` stays low for as long as the filtered manual reset is low, even when ticks arrive. The N-tick count starts only after the filtered input returns high.
- R5: `tmo_sel` picks the period as follows: 0 gives T_D1, 1 gives T_D2, 2 gives T_D3, 3 gives T_D5, 4 gives T_D6 and 5 gives T_D4, in rising length. Codes 6 and 7 give T_D3.
- R6: `mr_n` is resynchronized through SYNC_STAGES flops. A synchronized low must persist for MR_FILT_CYC consecutive clock edges before it counts as a reset, and a shorter low has no effect at `rst_n` or `rst_event`. A release is filtered the same way.
- R7: `rst_event` is high for exactly one cycle, in the cycle in which `rst_n` falls from high to low. It never pulses while `rst_n` is already low.
- R8: `rst_release` is high for exactly one cycle, in the cycle in which `rst_n` rises.
- R9: During and right after the asynchronous reset `arst_n`, `rst_n` is low, both strobes are low and the hold-off count is zero. The first release therefore needs the full N ticks.
- R10: A `tick_ms` pulse that arrives while a fault is present does not advance the hold-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| arst_n | input | 1 | Asynchronous power-on reset of the logic, active low |
| tick_ms | input | 1 | One-cycle time base enable that advances the hold-off |
| pg_pri | input | 1 | Primary rail good, synchronous |
| pg_sec | input | 1 | Secondary rail good, synchronous |
| pg_adj | input | 1 | Adjustable rail good, synchronous |
| mr_n | input | 1 | Manual reset, active low, asynchronous |
| tmo_sel | input | 3 | Hold-off period select |
| rst_n | output | 1 | System reset, active low |
| rst_event | output | 1 | One-cycle strobe on each new reset assertion |
| rst_release | output | 1 | One-cycle strobe when reset deasserts |

## Verification
A hold-off counter with the wrong value shows up directly at `rst_n`, which rises one or more ticks early or late. The bench counts every tick it issues and compares the release against the exact tick number for each select code. A counter that is not cleared on a fault shows up in the same way, as an early release after a restart within the same hold-off. A wrong filter count or synchronizer depth shows up within about ten cycles of a manual-reset edge, as a reset that appears for a spike that should be rejected, or as one that is missing for a press that should be accepted. Strobes that are stuck or doubled are seen in the cycle after the `rst_n` transition.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [2:0] {
    SEL_D1 = 3'd0,
    SEL_D2 = 3'd1,
    SEL_D3 = 3'd2,
    SEL_D5 = 3'd3,
    SEL_D6 = 3'd4,
    SEL_D4 = 3'd5
  } tmo_sel_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/supv_mr_filter.sv
module supv_mr_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYC    = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic mr_n_raw,
  output logic mr_n_filt
);
  localparam int unsigned FW = (FILT_CYC > 2) ? $clog2(FILT_CYC) : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   mr_s;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], mr_n_raw};
  end
  assign mr_s = sync_q[SYNC_STAGES-1];

  generate
    if (FILT_CYC <= 1) begin : g_nofilt
      assign mr_n_filt = mr_s;
    end else begin : g_filt
      logic [FW-1:0] run_q;
      logic          state_q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
          run_q   <= '0;
          state_q <= 1'b1;
        end else if (mr_s != state_q) begin
          if (run_q == FW'(FILT_CYC - 1)) begin
            state_q <= mr_s;
            run_q   <= '0;
          end else begin
            run_q <= run_q + FW'(1);
          end
        end else begin
          run_q <= '0;
        end
      end
      assign mr_n_filt = state_q;
    end
  endgenerate
endmodule

// File: rtl/supv_tmo_table.sv
module supv_tmo_table
  import supv_pkg::*;
#(
  parameter int unsigned CW   = 11,
  parameter int unsigned T_D1 = 2,
  parameter int unsigned T_D2 = 9,
  parameter int unsigned T_D3 = 140,
  parameter int unsigned T_D5 = 280,
  parameter int unsigned T_D6 = 560,
  parameter int unsigned T_D4 = 1120
) (
  input  logic [2:0]    sel,
  output logic [CW-1:0] limit
);
  always_comb begin
    case (sel)
      SEL_D1:  limit = CW'(T_D1);
      SEL_D2:  limit = CW'(T_D2);
      SEL_D3:  limit = CW'(T_D3);
      SEL_D5:  limit = CW'(T_D5);
      SEL_D6:  limit = CW'(T_D6);
      SEL_D4:  limit = CW'(T_D4);
      default: limit = CW'(T_D3);
    endcase
  end
endmodule

// File: rtl/supv_holdoff.sv
module supv_holdoff #(
  parameter int unsigned CW = 11
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          fault,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          asserted,
  output logic          event_p,
  output logic          release_p
);
  logic [CW-1:0] cnt_q;
  logic          asrt_q, ev_q, rel_q;
  logic          done;

  assign done = tick && (cnt_q >= limit - CW'(1));

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= '0;
      asrt_q <= 1'b1;
      ev_q   <= 1'b0;
      rel_q  <= 1'b0;
    end else begin
      ev_q  <= fault && !asrt_q;
      rel_q <= 1'b0;
      if (fault) begin
        cnt_q  <= '0;
        asrt_q <= 1'b1;
      end else if (asrt_q && tick) begin
        if (done) begin
          cnt_q  <= '0;
          asrt_q <= 1'b0;
          rel_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign asserted  = asrt_q;
  assign event_p   = ev_q;
  assign release_p = rel_q;
endmodule

// File: rtl/supv_rst_seq.sv
module supv_rst_seq
  import supv_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MR_FILT_CYC = 32,
  parameter int unsigned T_D1        = 2,
  parameter int unsigned T_D2        = 9,
  parameter int unsigned T_D3        = 140,
  parameter int unsigned T_D5        = 280,
  parameter int unsigned T_D6        = 560,
  parameter int unsigned T_D4        = 1120
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       tick_ms,
  input  logic       pg_pri,
  input  logic       pg_sec,
  input  logic       pg_adj,
  input  logic       mr_n,
  input  logic [2:0] tmo_sel,
  output logic       rst_n,
  output logic       rst_event,
  output logic       rst_release
);
  localparam int unsigned T_MAX = max2(max2(max2(T_D1, T_D2), max2(T_D3, T_D5)), max2(T_D6, T_D4));
  localparam int unsigned CW    = bits_for(T_MAX);

  logic          mr_ok;
  logic          fault;
  logic [CW-1:0] limit;
  logic          asserted;

  supv_mr_filter #(
    .SYNC_STAGES (SYNC_STAGES),
    .FILT_CYC    (MR_FILT_CYC)
  ) u_mr (
    .clk       (clk),
    .arst_n    (arst_n),
    .mr_n_raw  (mr_n),
    .mr_n_filt (mr_ok)
  );

  supv_tmo_table #(
    .CW   (CW),
    .T_D1 (T_D1),
    .T_D2 (T_D2),
    .T_D3 (T_D3),
    .T_D5 (T_D5),
    .T_D6 (T_D6),
    .T_D4 (T_D4)
  ) u_tbl (
    .sel   (tmo_sel),
    .limit (limit)
  );

  assign fault = !(pg_pri && pg_sec && pg_adj && mr_ok);

  supv_holdoff #(.CW(CW)) u_hold (
    .clk       (clk),
    .arst_n    (arst_n),
    .fault     (fault),
    .tick      (tick_ms),
    .limit     (limit),
    .asserted  (asserted),
    .event_p   (rst_event),
    .release_p (rst_release)
  );

  assign rst_n = !asserted;
endmodule

// File: rtl/supv_rst_seq_chk.sv
module supv_rst_seq_chk (
  input logic clk,
  input logic arst_n,
  input logic tick_ms,
  input logic pg_pri,
  input logic pg_sec,
  input logic pg_adj,
  input logic rst_n,
  input logic rst_event,
  input logic rst_release
);
  a_r1_flag_asserts: assert property (@(posedge clk) disable iff (!arst_n)
    (!pg_pri || !pg_sec || !pg_adj) |=> !rst_n);

  a_r2_rise_needs_tick: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n) |-> $past(tick_ms));

  a_r10_rise_needs_good: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n) |-> $past(pg_pri && pg_sec && pg_adj));

  a_r7_event_single: assert property (@(posedge clk) disable iff (!arst_n)
    rst_event |=> !rst_event);

  a_r7_event_on_fall: assert property (@(posedge clk) disable iff (!arst_n)
    rst_event |-> (!rst_n && $past(rst_n)));

  a_r8_release_on_rise: assert property (@(posedge clk) disable iff (!arst_n)
    rst_release |-> (rst_n && !$past(rst_n)));

  a_r8_rise_has_release: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n) |-> rst_release);

  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0({rst_event, rst_release}));
endmodule

bind supv_rst_seq supv_rst_seq_chk u_chk (
  .clk         (clk),
  .arst_n      (arst_n),
  .tick_ms     (tick_ms),
  .pg_pri      (pg_pri),
  .pg_sec      (pg_sec),
  .pg_adj      (pg_adj),
  .rst_n       (rst_n),
  .rst_event   (rst_event),
  .rst_release (rst_release)
);

// File: tb/supv_rst_seq_test.sv
module supv_rst_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int FILT = 4;
  localparam int LD1 = 2, LD2 = 3, LD3 = 4, LD5 = 5, LD6 = 6, LD4 = 8;

  logic clk = 1'b0, arst_n = 1'b0, tick_ms = 1'b0;
  logic pg_pri = 1'b1, pg_sec = 1'b1, pg_adj = 1'b1, mr_n = 1'b1;
  logic [2:0] tmo_sel = 3'd0;
  logic rst_n, rst_event, rst_release;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supv_rst_seq #(
    .SYNC_STAGES (2), .MR_FILT_CYC (FILT),
    .T_D1 (LD1), .T_D2 (LD2), .T_D3 (LD3), .T_D5 (LD5), .T_D6 (LD6), .T_D4 (LD4)
  ) uut (
    .clk (clk), .arst_n (arst_n), .tick_ms (tick_ms),
    .pg_pri (pg_pri), .pg_sec (pg_sec), .pg_adj (pg_adj), .mr_n (mr_n),
    .tmo_sel (tmo_sel), .rst_n (rst_n), .rst_event (rst_event), .rst_release (rst_release)
  );

  function automatic int exp_lim(input int s);
    case (s)
      0: return LD1;
      1: return LD2;
      2: return LD3;
      3: return LD5;
      4: return LD6;
      5: return LD4;
      default: return LD3;
    endcase
  endfunction

  task automatic expect_v(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic give_tick();
    @(negedge clk) tick_ms = 1'b1;
    @(negedge clk) tick_ms = 1'b0;
  endtask

  task automatic set_flag(input int which, input logic v);
    case (which % 3)
      0: pg_pri = v;
      1: pg_sec = v;
      default: pg_adj = v;
    endcase
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lim;
    int seen;
    // R9: state during and after power-on reset
    repeat (3) @(negedge clk);
    expect_v("R9 rst_n in reset", rst_n, 0);
    expect_v("R9 event in reset", rst_event, 0);
    expect_v("R9 release in reset", rst_release, 0);
    arst_n = 1'b1;
    @(negedge clk);
    expect_v("R9 rst_n after reset", rst_n, 0);
    give_tick();
    expect_v("R9 held after first tick", rst_n, 0);
    give_tick();
    expect_v("R9 release after full count", rst_n, 1);

    // R2 R5 R7 R8: sweep every select code, rotating the faulting flag
    for (int s = 0; s < 8; s++) begin
      lim = exp_lim(s);
      @(negedge clk);
      tmo_sel = 3'(s);
      set_flag(s, 1'b0);
      @(negedge clk);
      expect_v("R1 flag asserts reset", rst_n, 0);
      expect_v("R7 event on assert", rst_event, 1);
      set_flag(s, 1'b1);
      @(negedge clk);
      expect_v("R7 event one cycle", rst_event, 0);
      for (int t = 1; t < lim; t++) begin
        give_tick();
        expect_v("R5 still held before limit", rst_n, 0);
      end
      give_tick();
      expect_v("R2 R5 release on limit tick", rst_n, 1);
      expect_v("R8 release strobe", rst_release, 1);
      @(negedge clk);
      expect_v("R8 release one cycle", rst_release, 0);
    end

    // R3: restart on fault during hold-off, no second event
    tmo_sel = 3'd2;
    pg_pri = 1'b0;
    @(negedge clk) pg_pri = 1'b1;
    repeat (LD3 - 1) give_tick();
    expect_v("R3 held before restart", rst_n, 0);
    pg_sec = 1'b0;
    @(negedge clk);
    expect_v("R7 no event while asserted", rst_event, 0);
    pg_sec = 1'b1;
    repeat (LD3 - 1) give_tick();
    expect_v("R3 count restarted", rst_n, 0);
    give_tick();
    expect_v("R3 release after full restart", rst_n, 1);

    // R10: ticks during a held fault do not advance
    @(negedge clk) pg_adj = 1'b0;
    repeat (10) give_tick();
    expect_v("R10 held during fault", rst_n, 0);
    pg_adj = 1'b1;
    repeat (LD3 - 1) give_tick();
    expect_v("R10 no progress from fault ticks", rst_n, 0);
    give_tick();
    expect_v("R10 release after clean count", rst_n, 1);

    // R6: a short manual low is rejected
    tmo_sel = 3'd0;
    seen = 0;
    @(negedge clk) mr_n = 1'b0;
    repeat (FILT - 1) @(negedge clk);
    mr_n = 1'b1;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (rst_event || !rst_n) seen = 1;
    end
    expect_v("R6 short press ignored", seen, 0);

    // R6: a press of the filter length is accepted
    seen = 0;
    mr_n = 1'b0;
    repeat (FILT) @(negedge clk);
    mr_n = 1'b1;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (rst_event) seen = 1;
    end
    expect_v("R6 full press accepted", seen, 1);
    expect_v("R6 reset after press", rst_n, 0);
    repeat (LD1) give_tick();
    expect_v("R6 release after press", rst_n, 1);

    // R4: held manual reset blocks the hold-off
    @(negedge clk) mr_n = 1'b0;
    repeat (10) @(negedge clk);
    repeat (6) give_tick();
    expect_v("R4 held while pressed", rst_n, 0);
    mr_n = 1'b1;
    repeat (10) @(negedge clk);
    expect_v("R4 held after release without ticks", rst_n, 0);
    give_tick();
    expect_v("R4 held after one tick", rst_n, 0);
    give_tick();
    expect_v("R4 released after limit", rst_n, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule